// File: doc/BRIEF.md
# Buffered Output-Compare Timer Bank

This block holds a set of output-compare channels that watch a free-running time count supplied from outside. Each channel has a small control word and a two-deep compare store. A channel fires when the time count equals its active compare value, it is armed, and its mode field is non-zero. On each event it latches a sticky flag, can request an interrupt or a DMA transfer, and updates its output pin as the mode selects: the pin toggles, or it pulses high for one cycle.

Because the compare store is double-buffered, software writes the value for the event after the next one while the current one is still pending. After each event the queued value becomes active. If nothing is queued, the channel disarms and stays quiet until it is set up again. Software must clear the mode before it loads the first compare value. A compare value of zero, which the count reaches only when it wraps, is honoured only while the wrap-enable input is high.

Top module: `tcmp_bank`

## Requirements
- R1: After reset every flag, pin, DMA request and the interrupt are 0, and each control word reads back as 0x00.
- R2: The control word has DMA enable at bit 0, mode at bits 5:2, interrupt enable at bit 6 and the event flag at bit 7. Bit 1 always reads 0. Writing 1 to bit 7 clears the flag, and writing 0 to bit 7 leaves it as it is.
- R3: A channel that is armed and has a non-zero mode sets its flag in the cycle after the count equals its active compare value.
- R4: The first compare write to an unarmed channel arms the active value. A write to an armed channel queues the next value. At each event the queued value becomes active.
- R5: When an event finds nothing queued, the channel disarms, and a later return of the count to the same value raises no event.
- R6: In mode 0x5 the pin inverts on every event.
- R7: In mode 0xF the pin is high for exactly the one cycle after each event and low otherwise.
- R8: A compare write to an unarmed channel whose mode is non-zero is ignored.
- R9: Writing the all-zero control word discards both the active and the queued compare values.
- R10: A compare value of 0 matches only while wrap_en_i is high.
- R11: irq_o is the OR over channels of (flag AND interrupt enable), and dma_o[n] is the flag AND DMA enable of channel n.
- R12: flags_o bit n reflects the flag of channel n.
- R13: An event sets the flag even when a clear of the flag is written in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | CW | Current time count |
| wrap_en_i | input | 1 | Allow a compare value of zero to match |
| wr_en_i | input | 1 | Register write strobe |
| wr_ch_i | input | CHW | Channel addressed by the write |
| wr_cmp_i | input | 1 | 1 selects the compare store, 0 selects the control word |
| wr_data_i | input | 32 | Write data |
| rd_ch_i | input | CHW | Channel whose control word is read back |
| rd_ctrl_o | output | 8 | Control word of the selected channel |
| flags_o | output | NCH | Event flag of each channel |
| pin_o | output | NCH | Compare output pin of each channel |
| dma_o | output | NCH | DMA request of each channel |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The main sequence runs one channel in toggle mode through three events, so that an active value, a queued value and a value written after a swap are each consumed in order. The final event leaves nothing queued, and the count is then brought back to the same value, which separates "hold and stop" from "re-fire on the stale value". A second channel in pulse mode checks that the pin falls on the cycle after the event, which separates a one-cycle pulse from a level. Directed cases apply a flag clear in the same cycle as an event, a compare value of zero with and without wrap enable, and compare writes made while the mode is non-zero or just after an all-zero control write. Each of these cases has an outcome that a plausible wrong design would get different.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;
   localparam int CTRL_W  = 8;
   localparam int DRE_B   = 0;
   localparam int MODE_LO = 2;
   localparam int MODE_W  = 4;
   localparam int IE_B    = 6;
   localparam int FLAG_B  = 7;

   typedef logic [MODE_W-1:0] mode_t;
   localparam mode_t MODE_OFF    = 4'h0;
   localparam mode_t MODE_TOGGLE = 4'h5;
   localparam mode_t MODE_PULSE  = 4'hF;
endpackage

// File: rtl/tcmp_buf.sv
module tcmp_buf #(
   parameter int CW = 31
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_i,
   input  logic [CW-1:0] wr_val_i,
   input  logic          evt_i,
   input  logic          drop_i,
   output logic [CW-1:0] act_o,
   output logic          act_v_o
);
   logic [CW-1:0] pend_q;
   logic          pend_v_q;
   logic          keep_act;

   // the active slot stays occupied unless this event finds the queue empty
   assign keep_act = act_v_o && !(evt_i && !pend_v_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_o    <= '0;
         act_v_o  <= 1'b0;
         pend_q   <= '0;
         pend_v_q <= 1'b0;
      end else if (drop_i) begin
         act_v_o  <= 1'b0;
         pend_v_q <= 1'b0;
      end else begin
         if (evt_i) begin
            if (pend_v_q) begin
               act_o    <= pend_q;
               pend_v_q <= 1'b0;
            end else begin
               act_v_o  <= 1'b0;
            end
         end
         if (wr_i) begin
            if (keep_act) begin
               pend_q   <= wr_val_i;
               pend_v_q <= 1'b1;
            end else begin
               act_o    <= wr_val_i;
               act_v_o  <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/tcmp_chan.sv
module tcmp_chan
   import tcmp_pkg::*;
#(
   parameter int CW = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CW-1:0]     cnt_i,
   input  logic              wrap_en_i,
   input  logic              ctrl_we_i,
   input  logic              cmp_we_i,
   input  logic [31:0]       wdata_i,
   output logic [CTRL_W-1:0] ctrl_o,
   output logic              flag_o,
   output logic              pin_o,
   output logic              evt_o,
   output mode_t             mode_o
);
   logic          dre_q, ie_q;
   mode_t         mode_q;
   logic [CW-1:0] act;
   logic          act_v;
   logic          zero_wr, cmp_ok, at_zero;
   logic          unused_wbits;

   assign unused_wbits = ^wdata_i;
   assign zero_wr = ctrl_we_i && (wdata_i == 32'd0);
   // an unarmed channel takes its first compare value only with its mode cleared
   assign cmp_ok  = cmp_we_i && (act_v || (mode_q == MODE_OFF));
   assign at_zero = (act == '0);
   assign evt_o   = act_v && (mode_q != MODE_OFF) && (cnt_i == act)
                    && (!at_zero || wrap_en_i);

   tcmp_buf #(.CW(CW)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (cmp_ok),
      .wr_val_i(wdata_i[CW-1:0]),
      .evt_i   (evt_o),
      .drop_i  (zero_wr),
      .act_o   (act),
      .act_v_o (act_v)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dre_q  <= 1'b0;
         ie_q   <= 1'b0;
         mode_q <= MODE_OFF;
      end else if (ctrl_we_i) begin
         dre_q  <= wdata_i[DRE_B];
         ie_q   <= wdata_i[IE_B];
         mode_q <= wdata_i[MODE_LO +: MODE_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag_o <= 1'b0;
      else if (evt_o)
         flag_o <= 1'b1;
      else if (ctrl_we_i && wdata_i[FLAG_B])
         flag_o <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pin_o <= 1'b0;
      else begin
         case (mode_q)
            MODE_TOGGLE: if (evt_o) pin_o <= ~pin_o;
            MODE_PULSE:  pin_o <= evt_o;
            default:     pin_o <= pin_o;
         endcase
      end
   end

   assign mode_o = mode_q;
   assign ctrl_o = {flag_o, ie_q, mode_q, 1'b0, dre_q};
endmodule

// File: rtl/tcmp_bank.sv
module tcmp_bank
   import tcmp_pkg::*;
#(
   parameter int NCH = 4,
   parameter int CW  = 31,
   localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CW-1:0]     cnt_i,
   input  logic              wrap_en_i,
   input  logic              wr_en_i,
   input  logic [CHW-1:0]    wr_ch_i,
   input  logic              wr_cmp_i,
   input  logic [31:0]       wr_data_i,
   input  logic [CHW-1:0]    rd_ch_i,
   output logic [CTRL_W-1:0] rd_ctrl_o,
   output logic [NCH-1:0]    flags_o,
   output logic [NCH-1:0]    pin_o,
   output logic [NCH-1:0]    dma_o,
   output logic              irq_o
);
   localparam int MFW = NCH * MODE_W;

   if (NCH < 1 || NCH > 16) begin : g_bad_nch
      $error("tcmp_bank: NCH must lie in 1..16");
   end
   if (CW < 2 || CW > 32) begin : g_bad_cw
      $error("tcmp_bank: CW must lie in 2..32");
   end

   logic [CTRL_W-1:0] ctrl_w [NCH];
   logic [NCH-1:0]    evt_w;
   logic [NCH-1:0]    ie_w;
   logic [MFW-1:0]    mode_flat_w;

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      logic  sel;
      mode_t mode_g;
      if (NCH == 1) begin : g_one
         assign sel = 1'b1;
      end else begin : g_dec
         assign sel = (wr_ch_i == CHW'(g));
      end
      tcmp_chan #(.CW(CW)) u_ch (
         .clk      (clk),
         .rst_n    (rst_n),
         .cnt_i    (cnt_i),
         .wrap_en_i(wrap_en_i),
         .ctrl_we_i(wr_en_i && sel && !wr_cmp_i),
         .cmp_we_i (wr_en_i && sel && wr_cmp_i),
         .wdata_i  (wr_data_i),
         .ctrl_o   (ctrl_w[g]),
         .flag_o   (flags_o[g]),
         .pin_o    (pin_o[g]),
         .evt_o    (evt_w[g]),
         .mode_o   (mode_g)
      );
      assign ie_w[g]  = ctrl_w[g][IE_B];
      assign dma_o[g] = flags_o[g] & ctrl_w[g][DRE_B];
      assign mode_flat_w[g*MODE_W +: MODE_W] = mode_g;
   end

   assign irq_o = |(flags_o & ie_w);

   always_comb begin
      rd_ctrl_o = '0;
      for (int i = 0; i < NCH; i++)
         if (rd_ch_i == CHW'(i)) rd_ctrl_o = ctrl_w[i];
   end
endmodule

// File: rtl/tcmp_bank_chk.sv
module tcmp_bank_chk
   import tcmp_pkg::*;
#(
   parameter int NCH = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [NCH-1:0]        flags_o,
   input logic [NCH-1:0]        pin_o,
   input logic [NCH-1:0]        dma_o,
   input logic                  irq_o,
   input logic [NCH-1:0]        evt,
   input logic [NCH*MODE_W-1:0] mode_flat
);
   // R11
   irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (|flags_o));
   // R11
   dma_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_o & ~flags_o) == '0);

   for (genvar g = 0; g < NCH; g++) begin : g_c
      mode_t m;
      assign m = mode_flat[g*MODE_W +: MODE_W];
      // R3
      evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
         evt[g] |=> flags_o[g]);
      // R6
      toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (evt[g] && m == MODE_TOGGLE) |=> (pin_o[g] != $past(pin_o[g])));
      // R7
      pulse_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (evt[g] && m == MODE_PULSE) |=> pin_o[g]);
      // R7
      pulse_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (m == MODE_PULSE && $past(m) == MODE_PULSE && !$past(evt[g])) |-> !pin_o[g]);
   end
endmodule

bind tcmp_bank tcmp_bank_chk #(.NCH(NCH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .flags_o  (flags_o),
   .pin_o    (pin_o),
   .dma_o    (dma_o),
   .irq_o    (irq_o),
   .evt      (evt_w),
   .mode_flat(mode_flat_w)
);

// File: tb/tb_tcmp_bank.sv
module tb_tcmp_bank;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 4;
   localparam int CW  = 31;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [CW-1:0] cnt_i = '0;
   logic          wrap_en_i = 1'b0;
   logic          wr_en_i = 1'b0;
   logic [1:0]    wr_ch_i = '0;
   logic          wr_cmp_i = 1'b0;
   logic [31:0]   wr_data_i = '0;
   logic [1:0]    rd_ch_i = '0;
   logic [7:0]    rd_ctrl_o;
   logic [3:0]    flags_o, pin_o, dma_o;
   logic          irq_o;

   int checks = 0;
   int fails = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tcmp_bank #(.NCH(NCH), .CW(CW)) dut (
      .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .wrap_en_i(wrap_en_i),
      .wr_en_i(wr_en_i), .wr_ch_i(wr_ch_i), .wr_cmp_i(wr_cmp_i),
      .wr_data_i(wr_data_i), .rd_ch_i(rd_ch_i), .rd_ctrl_o(rd_ctrl_o),
      .flags_o(flags_o), .pin_o(pin_o), .dma_o(dma_o), .irq_o(irq_o)
   );

   // op: 0 idle, 1 control write, 2 compare write
   typedef struct packed {
      logic [1:0]  op;
      logic [1:0]  ch;
      logic [31:0] data;
      logic [30:0] cnt;
      logic [3:0]  fl;
      logic [3:0]  pn;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VEC [NV] = '{
      '{2'd1, 2'd0, 32'h00, 31'd0,  4'h0, 4'h0},  // R2 mode cleared
      '{2'd2, 2'd0, 32'd10, 31'd1,  4'h0, 4'h0},  // R4 arm 10
      '{2'd2, 2'd0, 32'd20, 31'd2,  4'h0, 4'h0},  // R4 queue 20
      '{2'd1, 2'd0, 32'h54, 31'd3,  4'h0, 4'h0},  // toggle, ie
      '{2'd0, 2'd0, 32'h00, 31'd10, 4'h1, 4'h1},  // R3 R6 event at 10
      '{2'd1, 2'd0, 32'hD4, 31'd11, 4'h0, 4'h1},  // R2 w1c
      '{2'd2, 2'd0, 32'd30, 31'd12, 4'h0, 4'h1},  // R4 queue after swap
      '{2'd0, 2'd0, 32'h00, 31'd20, 4'h1, 4'h0},  // R4 R6 event at 20
      '{2'd1, 2'd0, 32'hD4, 31'd21, 4'h0, 4'h0},
      '{2'd0, 2'd0, 32'h00, 31'd30, 4'h1, 4'h1},  // R4 event at 30
      '{2'd1, 2'd0, 32'hD4, 31'd31, 4'h0, 4'h1},
      '{2'd0, 2'd0, 32'h00, 31'd30, 4'h0, 4'h1},  // R5 no refire
      '{2'd2, 2'd1, 32'd40, 31'd0,  4'h0, 4'h1},
      '{2'd1, 2'd1, 32'h3C, 31'd1,  4'h0, 4'h1},  // pulse mode
      '{2'd0, 2'd0, 32'h00, 31'd40, 4'h2, 4'h3},  // R7 R12 pulse high
      '{2'd0, 2'd0, 32'h00, 31'd41, 4'h2, 4'h1}   // R7 pulse low
   };

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got=0x%0h exp=0x%0h", tag, got, exp);
      end
   endtask

   task automatic cyc(input logic [1:0] op, input logic [1:0] ch,
                      input logic [31:0] data, input logic [30:0] cnt);
      @(negedge clk);
      wr_en_i   = (op != 2'd0);
      wr_cmp_i  = (op == 2'd2);
      wr_ch_i   = ch;
      wr_data_i = data;
      cnt_i     = cnt;
      @(posedge clk);
      #1;
      wr_en_i = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R1 flags", 32'(flags_o), 0);
      chk("R1 pins", 32'(pin_o), 0);
      chk("R1 irq/dma", {27'd0, irq_o, dma_o}, 0);
      chk("R1 ctrl", 32'(rd_ctrl_o), 0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         cyc(VEC[i].op, VEC[i].ch, VEC[i].data, VEC[i].cnt);
         chk($sformatf("R4 vec%0d flags", i), 32'(flags_o), 32'(VEC[i].fl));
         chk($sformatf("R6 vec%0d pins", i), 32'(pin_o), 32'(VEC[i].pn));
      end

      rd_ch_i = 2'd0; #1;
      chk("R2 ctrl ch0", 32'(rd_ctrl_o), 32'h54);
      rd_ch_i = 2'd1; #1;
      chk("R2 ctrl ch1 with flag", 32'(rd_ctrl_o), 32'hBC);
      chk("R11 irq off when ie low", 32'(irq_o), 0);

      // R8 compare write ignored while unarmed with mode set
      cyc(2'd1, 2'd2, 32'hFF, 31'd0);
      rd_ch_i = 2'd2; #1;
      chk("R2 bit1 reads zero", 32'(rd_ctrl_o), 32'h7D);
      cyc(2'd2, 2'd2, 32'd50, 31'd0);
      cyc(2'd0, 2'd0, 32'd0, 31'd50);
      chk("R8 no event", 32'(flags_o[2]), 0);
      cyc(2'd1, 2'd2, 32'h00, 31'd0);
      cyc(2'd2, 2'd2, 32'd50, 31'd0);
      cyc(2'd1, 2'd2, 32'h7D, 31'd0);
      cyc(2'd0, 2'd0, 32'd0, 31'd50);
      chk("R12 flag ch2", 32'(flags_o), 32'h6);
      chk("R11 irq", 32'(irq_o), 1);
      chk("R11 dma", 32'(dma_o), 32'h4);

      // R13 clear collides with an event
      cyc(2'd1, 2'd3, 32'h00, 31'd0);
      cyc(2'd2, 2'd3, 32'd70, 31'd0);
      cyc(2'd2, 2'd3, 32'd80, 31'd0);
      cyc(2'd1, 2'd3, 32'h3C, 31'd0);
      cyc(2'd0, 2'd0, 32'd0, 31'd70);
      chk("R3 ch3 first event", 32'(flags_o[3]), 1);
      cyc(2'd1, 2'd3, 32'hBC, 31'd80);
      chk("R13 set wins", 32'(flags_o[3]), 1);
      cyc(2'd1, 2'd3, 32'hBC, 31'd1);
      chk("R2 w1c ch3", 32'(flags_o[3]), 0);

      // R10 zero compare value
      cyc(2'd1, 2'd3, 32'h00, 31'd1);
      cyc(2'd2, 2'd3, 32'd0, 31'd1);
      cyc(2'd1, 2'd3, 32'h3C, 31'd1);
      wrap_en_i = 1'b0;
      cyc(2'd0, 2'd0, 32'd0, 31'd0);
      chk("R10 blocked without wrap", 32'(flags_o[3]), 0);
      wrap_en_i = 1'b1;
      cyc(2'd0, 2'd0, 32'd0, 31'd0);
      chk("R10 fires with wrap", 32'(flags_o[3]), 1);
      wrap_en_i = 1'b0;

      // R9 zero control word drops armed and queued values
      cyc(2'd1, 2'd1, 32'h80, 31'd1);
      cyc(2'd1, 2'd1, 32'h00, 31'd1);
      cyc(2'd2, 2'd1, 32'd90, 31'd1);
      cyc(2'd2, 2'd1, 32'd95, 31'd1);
      cyc(2'd1, 2'd1, 32'h00, 31'd1);
      cyc(2'd1, 2'd1, 32'h3C, 31'd1);
      cyc(2'd0, 2'd0, 32'd0, 31'd90);
      chk("R9 active dropped", 32'(flags_o[1]), 0);
      cyc(2'd0, 2'd0, 32'd0, 31'd95);
      chk("R9 queued dropped", 32'(flags_o[1]), 0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule